// File: doc/BRIEF.md
# Multichannel Period and High-Time Meter

This block times several independent digital inputs. Each input has one pin. For each channel the block reports two values: the length of the most recent full period and the length of the most recent high phase. Both values are counted in cycles of the block's own clock. Every pin passes through a synchroniser and then an edge detector. A single counter per channel restarts on each rising edge. When the next rising edge arrives, the counter value is kept as the period. When a falling edge arrives, the counter value is kept as the high time.

Software reads the results through a plain register port with combinational read data. A read-only word reports the clock frequency in Hz, fixed at build time, so that software can convert tick counts into time. A write to the control word with bit 0 set clears every channel, including its synchroniser. The port has no handshake: the read data follows the address in the same cycle. The block has no streamed data, so valid/ready does not apply.

Top module: `pw_meter`

## Requirements
- R1: After rst_n is released, every channel's period and high-time registers read 0.
- R2: A channel's period register holds the number of clock cycles between its two most recent rising edges. The value changes on the third rising clock edge after the pin rises: two synchroniser flops, then the capture.
- R3: A channel's high-time register holds the number of clock cycles from its most recent rising edge to the falling edge that follows it.
- R4: Both registers of a channel read 0 until that channel has seen two rising edges, which is one full period.
- R5: The per-channel counter saturates at 2^CNT_W-1. A period or high phase longer than that reads as 2^CNT_W-1.
- R6: Between edges, both registers hold the last complete measurement, however long the input stays still.
- R7: A read of address 0x20 returns the parameter BASE_HZ.
- R8: A write to address 0x04 with bit 0 = 1 clears all channels, both registers and the synchronisers, within two cycles. A write to 0x04 with bit 0 = 0 changes nothing.
- R9: Address 0x00 (status), address 0x04 (control) and all unmapped addresses read 0.
- R10: For channel i, the period is at address 0x28+8*i and the high time is at address 0x2C+8*i. The channels do not affect each other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock; all counts are in its cycles |
| rst_n | input | 1 | Asynchronous active-low reset |
| meas_in | input | NCH | One asynchronous input pin per channel |
| reg_addr | input | 8 | Byte address of the register port |
| reg_wr | input | 1 | Write strobe, sampled on the rising clock edge |
| reg_wdata | input | 32 | Write data; only bit 0 at address 0x04 has an effect |
| reg_rdata | output | 32 | Read data for reg_addr, combinational |

## Verification
The assertions assume that rst_n is asserted from time zero. They also treat a self-clear as a reset, so their checks pause while it is in effect. The logic assumes that the pins are low when a reset or self-clear ends, because a pin that is already high at that moment appears as a rising edge. The stimulus changes pins and register inputs only on falling clock edges. It holds every pin low around each reset and self-clear, and it keeps each test's periods within the counter range, except where saturation is the point of the test.

// File: rtl/pw_meter_pkg.sv
package pw_meter_pkg;
  localparam int REG_W  = 32;
  localparam int ADDR_W = 8;

  localparam logic [ADDR_W-1:0] ADDR_STAT = 8'h00;
  localparam logic [ADDR_W-1:0] ADDR_CTRL = 8'h04;
  localparam logic [ADDR_W-1:0] ADDR_BASE = 8'h20;
  localparam logic [ADDR_W-1:0] ADDR_CH0  = 8'h28;
  localparam int CH_STRIDE = 8;

  typedef struct packed {
    logic [REG_W-1:0] period;
    logic [REG_W-1:0] high;
  } meas_t;

  function automatic logic [ADDR_W-1:0] chan_addr(input int ch, input logic hi_sel);
    return ADDR_W'(int'(ADDR_CH0) + ch * CH_STRIDE + (hi_sel ? 4 : 0));
  endfunction
endpackage

// File: rtl/pw_edge_sync.sv
module pw_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic din,
  output logic rise,
  output logic fall
);
  // sh[STAGES-1] is the synchronised level, sh[STAGES] its previous value
  logic [STAGES:0] sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   sh <= '0;
    else if (clr) sh <= '0;
    else          sh <= {sh[STAGES-1:0], din};
  end

  assign rise = sh[STAGES-1] & ~sh[STAGES];
  assign fall = ~sh[STAGES-1] & sh[STAGES];

  // R2
  rise_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n || clr)
    rise |=> !rise);
  // R3
  fall_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n || clr)
    fall |=> !fall);
endmodule

// File: rtl/pw_chan.sv
module pw_chan
  import pw_meter_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             rise,
  input  logic             fall,
  output logic [REG_W-1:0] period_o,
  output logic [REG_W-1:0] high_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt, per_q, hi_q;
  logic             seen_q, valid_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0; per_q <= '0; hi_q <= '0; seen_q <= 1'b0; valid_q <= 1'b0;
    end else if (clr) begin
      cnt <= '0; per_q <= '0; hi_q <= '0; seen_q <= 1'b0; valid_q <= 1'b0;
    end else begin
      if (rise) begin
        cnt    <= CNT_ONE;
        seen_q <= 1'b1;
        if (seen_q) begin
          per_q   <= cnt;
          valid_q <= 1'b1;
        end
      end else if (cnt != CNT_MAX) begin
        cnt <= cnt + CNT_ONE;
      end
      if (fall && seen_q) hi_q <= cnt;
    end
  end

  assign period_o = REG_W'(per_q);
  assign high_o   = valid_q ? REG_W'(hi_q) : '0;

  // R2
  cnt_restart_chk: assert property (@(posedge clk) disable iff (!rst_n || clr)
    rise |=> cnt == CNT_ONE);
  // R5
  cnt_sat_chk: assert property (@(posedge clk) disable iff (!rst_n || clr)
    (cnt == CNT_MAX && !rise) |=> cnt == CNT_MAX);
  // R6
  period_hold_chk: assert property (@(posedge clk) disable iff (!rst_n || clr)
    !rise |=> $stable(period_o));
  // R6
  high_hold_chk: assert property (@(posedge clk) disable iff (!rst_n || clr)
    (!rise && !fall) |=> $stable(high_o));
  // R4
  zero_until_valid_chk: assert property (@(posedge clk) disable iff (!rst_n || clr)
    !valid_q |-> (period_o == '0 && high_o == '0));
endmodule

// File: rtl/pw_regs.sv
module pw_regs
  import pw_meter_pkg::*;
#(
  parameter int NCH     = 4,
  parameter int BASE_HZ = 250_000_000
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [ADDR_W-1:0]     addr,
  input  logic                  wr,
  input  logic [REG_W-1:0]      wdata,
  input  meas_t [NCH-1:0]       meas,
  output logic [REG_W-1:0]      rdata,
  output logic                  soft_rst
);
  logic clr_req;
  logic unused_wbits;

  assign clr_req      = wr && (addr == ADDR_CTRL) && wdata[0];
  assign unused_wbits = ^wdata[REG_W-1:1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) soft_rst <= 1'b0;
    else        soft_rst <= clr_req;
  end

  always_comb begin
    rdata = '0;
    if (addr == ADDR_BASE) rdata = REG_W'(BASE_HZ);
    for (int c = 0; c < NCH; c++) begin
      if (addr == chan_addr(c, 1'b0)) rdata = meas[c].period;
      if (addr == chan_addr(c, 1'b1)) rdata = meas[c].high;
    end
  end

  // R9
  stat_ctrl_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == ADDR_STAT || addr == ADDR_CTRL) |-> rdata == '0);
  // R7
  base_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == ADDR_BASE) |-> rdata == REG_W'(BASE_HZ));
  // R8
  soft_rst_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && addr == ADDR_CTRL && !wdata[0]) |=> !soft_rst);
endmodule

// File: rtl/pw_meter.sv
module pw_meter
  import pw_meter_pkg::*;
#(
  parameter int NCH         = 4,            // channel count, at most 27 with 8-bit addresses
  parameter int CNT_W       = 32,           // counter width, at most 32
  parameter int BASE_HZ     = 250_000_000,  // clock frequency reported at 0x20
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NCH-1:0]    meas_in,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata
);
  logic           soft_rst;
  logic [NCH-1:0] rise, fall;
  meas_t [NCH-1:0] meas;

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    pw_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk (clk), .rst_n (rst_n), .clr (soft_rst),
      .din (meas_in[g]), .rise (rise[g]), .fall (fall[g])
    );
    pw_chan #(.CNT_W(CNT_W)) u_chan (
      .clk (clk), .rst_n (rst_n), .clr (soft_rst),
      .rise (rise[g]), .fall (fall[g]),
      .period_o (meas[g].period), .high_o (meas[g].high)
    );
  end

  pw_regs #(.NCH(NCH), .BASE_HZ(BASE_HZ)) u_regs (
    .clk (clk), .rst_n (rst_n), .addr (reg_addr), .wr (reg_wr),
    .wdata (reg_wdata), .meas (meas), .rdata (reg_rdata), .soft_rst (soft_rst)
  );
endmodule

// File: tb/tb_pw_meter.sv
module tb_pw_meter;
  localparam int NCH = 4;
  localparam int CW  = 8;
  localparam int HZ  = 250_000_000;
  localparam logic [31:0] SAT = 32'd255;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [NCH-1:0] meas_in = '0;
  logic [7:0]  reg_addr = '0;
  logic        reg_wr = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;

  int checks = 0;
  int failures = 0;

  always #2 clk = ~clk;  // 250 MHz

  pw_meter #(.NCH(NCH), .CNT_W(CW), .BASE_HZ(HZ)) dut (
    .clk (clk), .rst_n (rst_n), .meas_in (meas_in), .reg_addr (reg_addr),
    .reg_wr (reg_wr), .reg_wdata (reg_wdata), .reg_rdata (reg_rdata)
  );

  function automatic logic [7:0] per_a(input int c);
    return 8'(8'h28 + 8 * c);
  endfunction
  function automatic logic [7:0] hi_a(input int c);
    return 8'(8'h2C + 8 * c);
  endfunction

  task automatic chk_reg(input string req, input logic [7:0] a, input logic [31:0] exp);
    logic [31:0] v;
    reg_addr = a;
    #1;
    v = reg_rdata;
    checks++;
    if (v !== exp) begin
      failures++;
      $display("FAIL %s addr=0x%02h actual=%0d expected=%0d", req, a, v, exp);
    end
  endtask

  task automatic wr_reg(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0; reg_wdata = '0;
    repeat (2) @(negedge clk);
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset_state;
    for (int c = 0; c < NCH; c++) begin
      chk_reg("R1 period after reset", per_a(c), 32'd0);
      chk_reg("R1 high after reset", hi_a(c), 32'd0);
    end
    chk_reg("R7 base clock", 8'h20, 32'(HZ));
    chk_reg("R9 status", 8'h00, 32'd0);
    chk_reg("R9 control", 8'h04, 32'd0);
    chk_reg("R9 unmapped", 8'h10, 32'd0);
    chk_reg("R9 unmapped past channels", 8'h48, 32'd0);
  endtask

  task automatic t_first_period;
    wr_reg(8'h04, 32'd1);
    @(negedge clk); meas_in[0] = 1'b1;
    wait_cyc(5);    meas_in[0] = 1'b0;
    wait_cyc(7);
    chk_reg("R4 period before full period", per_a(0), 32'd0);
    chk_reg("R4 high before full period", hi_a(0), 32'd0);
    meas_in[0] = 1'b1;
    wait_cyc(3);    meas_in[0] = 1'b0;
    wait_cyc(6);
    chk_reg("R2 first period", per_a(0), 32'd12);
    chk_reg("R3 high after first period", hi_a(0), 32'd3);
  endtask

  task automatic t_latency;
    wr_reg(8'h04, 32'd1);
    @(negedge clk); meas_in[1] = 1'b1;
    wait_cyc(4);    meas_in[1] = 1'b0;
    wait_cyc(6);    meas_in[1] = 1'b1;
    wait_cyc(2);
    chk_reg("R2 period not yet captured", per_a(1), 32'd0);
    wait_cyc(1);
    chk_reg("R2 period on third edge", per_a(1), 32'd10);
    meas_in[1] = 1'b0;
    wait_cyc(5);
  endtask

  task automatic t_saturate;
    wr_reg(8'h04, 32'd1);
    @(negedge clk); meas_in[2] = 1'b1;
    wait_cyc(2);    meas_in[2] = 1'b0;
    wait_cyc(3);    meas_in[2] = 1'b1;
    wait_cyc(300);  meas_in[2] = 1'b0;
    wait_cyc(10);
    chk_reg("R5 long high saturates", hi_a(2), SAT);
    chk_reg("R6 period held through long high", per_a(2), 32'd5);
    wait_cyc(290);  meas_in[2] = 1'b1;
    wait_cyc(2);    meas_in[2] = 1'b0;
    wait_cyc(10);
    chk_reg("R5 long period saturates", per_a(2), SAT);
    chk_reg("R3 short high after saturation", hi_a(2), 32'd2);
  endtask

  task automatic t_multi;
    int per [NCH] = '{10, 17, 6, 40};
    int hi  [NCH] = '{3, 9, 1, 39};
    int cyc [NCH] = '{100, 170, 60, 120};
    wr_reg(8'h04, 32'd1);
    for (int t = 0; t < 170; t++) begin
      @(negedge clk);
      for (int c = 0; c < NCH; c++)
        meas_in[c] = (t < cyc[c]) && ((t % per[c]) < hi[c]);
    end
    @(negedge clk); meas_in = '0;
    wait_cyc(8);
    for (int c = 0; c < NCH; c++) begin
      chk_reg("R10 per-channel period", per_a(c), 32'(per[c]));
      chk_reg("R10 per-channel high", hi_a(c), 32'(hi[c]));
    end
    wait_cyc(600);
    for (int c = 0; c < NCH; c++) begin
      chk_reg("R6 period held while idle", per_a(c), 32'(per[c]));
      chk_reg("R6 high held while idle", hi_a(c), 32'(hi[c]));
    end
    wr_reg(8'h04, 32'd2);
    chk_reg("R8 write without bit 0 keeps period", per_a(3), 32'd40);
    chk_reg("R8 write without bit 0 keeps high", hi_a(1), 32'd9);
    wr_reg(8'h04, 32'd1);
    for (int c = 0; c < NCH; c++) begin
      chk_reg("R8 self-clear period", per_a(c), 32'd0);
      chk_reg("R8 self-clear high", hi_a(c), 32'd0);
    end
  endtask

  initial begin
    wait_cyc(4);
    rst_n = 1'b1;
    wait_cyc(2);
    t_reset_state();
    t_first_period();
    t_latency();
    t_saturate();
    t_multi();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule